// File: doc/BRIEF.md
# Sensor-Actuated Intersection Signal Controller

This block sequences the lamps of a four-way junction. The north-south main street carries through lanes A and B and two protected left-turn lanes, L1 and L2. The east-west side street, lane C, carries through traffic only. One crosswalk signal serves the main street and one serves the side street. Without pending requests the controller alternates between the main-street green and the side-street green. Each change passes through a yellow interval and then a single all-red clock.

Push buttons for the pedestrian crossing and for each left-turn lane give one-clock pulses. The controller holds each pulse until the phase that serves it. The first all-red point samples the pedestrian request, which can replace the side-street green with a longer green that also lights the walk lamp. The second all-red point samples both turn requests, which can insert an L1-only, an L2-only or a dual left-turn phase before the main-street green comes back. Three dwell counters set the lengths: a long one for main and turn greens, one for the side green, and one for every yellow.

Top module: `xing_signal_ctrl`

## Requirements
- R1: An active-high `rst` acts at once without waiting for a clock edge. It puts the controller in the main-green state: A and B green, the main walk lamp lit, every other head red, and no request pending.
- R2: Default cycle with no requests: main green (A, B green, walk_ab lit) for LONG_TICKS=9 clocks, A/B yellow for AMBER_TICKS=4, all red 1, C green for SIDE_TICKS=6, C yellow 4, all red 1, then main green again.
- R3: Each vehicle head is a 3-bit one-hot vector with bit 2 green, bit 1 yellow and bit 0 red. Red lights whenever neither green nor yellow is driven. Each crosswalk drives exactly one of walk and don't-walk, and the lane-C crosswalk always shows don't-walk.
- R4: While lane C shows green or yellow, heads A, B, L1 and L2 all show red.
- R5: If a pedestrian request is pending at the first all-red clock, C shows green with walk_ab lit for 9 clocks, then C yellow for 4, all red for 1, then main green.
- R6: If only an L1 request is pending at the second all-red clock: L1 and B green for 9 clocks, then L1 yellow with A green for 4, then A green alone for 1, then main green.
- R7: If only an L2 request is pending at the second all-red clock: L2 and A green for 9 clocks, then L2 yellow with B green for 4, then B green alone for 1, then main green.
- R8: If both turn requests are pending at the second all-red clock: L1 and L2 green for 9 clocks, both yellow for 4, all red for 1, then main green.
- R9: A one-clock request pulse stays pending until its phase is entered. Entering the phase clears it, so the following cycle follows the default path.
- R10: A request pulse that arrives while its own phase is running is kept, and the next cycle serves it again.
- R11: A head that shows yellow shows yellow or red on the next clock, never green.
- R12: Every all-red interval lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one tick per timing unit |
| rst | input | 1 | Asynchronous reset, active high |
| req_left1 | input | 1 | Vehicle waiting in left-turn lane L1 (pulse) |
| req_left2 | input | 1 | Vehicle waiting in left-turn lane L2 (pulse) |
| req_walk | input | 1 | Pedestrian crossing request (pulse) |
| head_a | output | 3 | Lane A lamps {green, yellow, red} |
| head_b | output | 3 | Lane B lamps {green, yellow, red} |
| head_c | output | 3 | Lane C lamps {green, yellow, red} |
| head_l1 | output | 3 | Left-turn L1 lamps {green, yellow, red} |
| head_l2 | output | 3 | Left-turn L2 lamps {green, yellow, red} |
| walk_ab | output | 1 | Main-street crosswalk walk lamp |
| dontwalk_ab | output | 1 | Main-street crosswalk don't-walk lamp |
| walk_c | output | 1 | Side-street crosswalk walk lamp |
| dontwalk_c | output | 1 | Side-street crosswalk don't-walk lamp |

## Verification
The assertions check on every clock that each head is one-hot and each crosswalk is complementary, that a lit side street keeps every main and turn head red, that yellow never returns to green, and that an all-red interval never lasts beyond one clock. Some behaviour only the directed scenarios can show: the exact dwell of each interval, which branch each combination of requests picks, that a served request is consumed, and that a request made during its own phase is served again on the next cycle.

// File: rtl/xing_signal_ctrl.sv
module xing_signal_ctrl #(
  parameter int LONG_TICKS  = 9,
  parameter int SIDE_TICKS  = 6,
  parameter int AMBER_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_left1,
  input  logic       req_left2,
  input  logic       req_walk,
  output logic [2:0] head_a,
  output logic [2:0] head_b,
  output logic [2:0] head_c,
  output logic [2:0] head_l1,
  output logic [2:0] head_l2,
  output logic       walk_ab,
  output logic       dontwalk_ab,
  output logic       walk_c,
  output logic       dontwalk_c
);
  localparam int LW = $clog2(LONG_TICKS + 1);
  localparam int SW = $clog2(SIDE_TICKS + 1);
  localparam int AW = $clog2(AMBER_TICKS + 1);

  typedef enum logic [3:0] {
    ST_MAIN_GO, ST_MAIN_AMB, ST_HOLD_1, ST_SIDE_GO, ST_SIDE_AMB, ST_HOLD_2,
    ST_PED_GO, ST_L1_GO, ST_L1_AMB, ST_L1_CLR, ST_L2_GO, ST_L2_AMB, ST_L2_CLR,
    ST_DUAL_GO, ST_DUAL_AMB, ST_DUAL_HOLD
  } st_t;

  st_t state, state_nx;
  logic [LW-1:0] cnt_long;
  logic [SW-1:0] cnt_side;
  logic [AW-1:0] cnt_amb;
  logic pend_l1, pend_l2, pend_walk;

  wire en_long = state inside {ST_MAIN_GO, ST_PED_GO, ST_L1_GO, ST_L2_GO, ST_DUAL_GO};
  wire en_side = (state == ST_SIDE_GO);
  wire en_amb  = state inside {ST_MAIN_AMB, ST_SIDE_AMB, ST_L1_AMB, ST_L2_AMB, ST_DUAL_AMB};

  wire long_done = en_long && (cnt_long == LW'(LONG_TICKS - 1));
  wire side_done = en_side && (cnt_side == SW'(SIDE_TICKS - 1));
  wire amb_done  = en_amb  && (cnt_amb  == AW'(AMBER_TICKS - 1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_long <= '0;
      cnt_side <= '0;
      cnt_amb  <= '0;
    end else begin
      cnt_long <= (en_long && !long_done) ? cnt_long + 1'b1 : '0;
      cnt_side <= (en_side && !side_done) ? cnt_side + 1'b1 : '0;
      cnt_amb  <= (en_amb  && !amb_done)  ? cnt_amb  + 1'b1 : '0;
    end
  end

  wire serve_walk = (state == ST_HOLD_1) && pend_walk;
  wire serve_l1   = (state == ST_HOLD_2) && pend_l1;
  wire serve_l2   = (state == ST_HOLD_2) && pend_l2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pend_l1   <= 1'b0;
      pend_l2   <= 1'b0;
      pend_walk <= 1'b0;
      state     <= ST_MAIN_GO;
    end else begin
      pend_l1   <= (pend_l1   && !serve_l1)   || req_left1;
      pend_l2   <= (pend_l2   && !serve_l2)   || req_left2;
      pend_walk <= (pend_walk && !serve_walk) || req_walk;
      state     <= state_nx;
    end
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_MAIN_GO:   if (long_done) state_nx = ST_MAIN_AMB;
      ST_MAIN_AMB:  if (amb_done)  state_nx = ST_HOLD_1;
      ST_HOLD_1:    state_nx = pend_walk ? ST_PED_GO : ST_SIDE_GO;
      ST_SIDE_GO:   if (side_done) state_nx = ST_SIDE_AMB;
      ST_PED_GO:    if (long_done) state_nx = ST_SIDE_AMB;
      ST_SIDE_AMB:  if (amb_done)  state_nx = ST_HOLD_2;
      ST_HOLD_2: begin
        if (pend_l1 && pend_l2) state_nx = ST_DUAL_GO;
        else if (pend_l1)       state_nx = ST_L1_GO;
        else if (pend_l2)       state_nx = ST_L2_GO;
        else                    state_nx = ST_MAIN_GO;
      end
      ST_L1_GO:     if (long_done) state_nx = ST_L1_AMB;
      ST_L1_AMB:    if (amb_done)  state_nx = ST_L1_CLR;
      ST_L2_GO:     if (long_done) state_nx = ST_L2_AMB;
      ST_L2_AMB:    if (amb_done)  state_nx = ST_L2_CLR;
      ST_DUAL_GO:   if (long_done) state_nx = ST_DUAL_AMB;
      ST_DUAL_AMB:  if (amb_done)  state_nx = ST_DUAL_HOLD;
      default:      state_nx = ST_MAIN_GO;
    endcase
  end

  wire a_g  = state inside {ST_MAIN_GO, ST_L1_AMB, ST_L1_CLR, ST_L2_GO};
  wire a_y  = (state == ST_MAIN_AMB);
  wire b_g  = state inside {ST_MAIN_GO, ST_L1_GO, ST_L2_AMB, ST_L2_CLR};
  wire b_y  = (state == ST_MAIN_AMB);
  wire c_g  = state inside {ST_SIDE_GO, ST_PED_GO};
  wire c_y  = (state == ST_SIDE_AMB);
  wire l1_g = state inside {ST_L1_GO, ST_DUAL_GO};
  wire l1_y = state inside {ST_L1_AMB, ST_DUAL_AMB};
  wire l2_g = state inside {ST_L2_GO, ST_DUAL_GO};
  wire l2_y = state inside {ST_L2_AMB, ST_DUAL_AMB};

  assign head_a  = {a_g,  a_y,  !a_g  && !a_y};
  assign head_b  = {b_g,  b_y,  !b_g  && !b_y};
  assign head_c  = {c_g,  c_y,  !c_g  && !c_y};
  assign head_l1 = {l1_g, l1_y, !l1_g && !l1_y};
  assign head_l2 = {l2_g, l2_y, !l2_g && !l2_y};

  assign walk_ab     = state inside {ST_MAIN_GO, ST_PED_GO};
  assign dontwalk_ab = !walk_ab;
  assign walk_c      = 1'b0;
  assign dontwalk_c  = 1'b1;

  logic [4:0][2:0] heads;
  assign heads = {head_a, head_b, head_c, head_l1, head_l2};
  wire all_red = head_a[0] && head_b[0] && head_c[0] && head_l1[0] && head_l2[0];

  for (genvar i = 0; i < 5; i++) begin : g_head_chk
    AST_HEAD_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(heads[i]) == 1); // R3
    AST_AMBER_THEN_RED: assert property (@(posedge clk) disable iff (rst)
      heads[i][1] |=> (heads[i][1] || heads[i][0])); // R11
  end

  AST_CROSS_EXCL: assert property (@(posedge clk) disable iff (rst)
    (walk_ab != dontwalk_ab) && (walk_c != dontwalk_c)); // R3
  AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !head_c[0] |-> (head_a[0] && head_b[0] && head_l1[0] && head_l2[0])); // R4
  AST_ALLRED_ONE: assert property (@(posedge clk) disable iff (rst)
    all_red |=> !all_red); // R12
endmodule

// File: tb/xing_signal_ctrl_tb.sv
module xing_signal_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_left1 = 1'b0, req_left2 = 1'b0, req_walk = 1'b0;
  logic [2:0] head_a, head_b, head_c, head_l1, head_l2;
  logic walk_ab, dontwalk_ab, walk_c, dontwalk_c;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xing_signal_ctrl u_dut (
    .clk(clk), .rst(rst), .req_left1(req_left1), .req_left2(req_left2), .req_walk(req_walk),
    .head_a(head_a), .head_b(head_b), .head_c(head_c), .head_l1(head_l1), .head_l2(head_l2),
    .walk_ab(walk_ab), .dontwalk_ab(dontwalk_ab), .walk_c(walk_c), .dontwalk_c(dontwalk_c)
  );

  wire [18:0] obs = {head_a, head_b, head_c, head_l1, head_l2, walk_ab, dontwalk_ab, walk_c, dontwalk_c};

  localparam logic [2:0] G = 3'b100, Y = 3'b010, R = 3'b001;
  localparam logic [18:0] P_MG  = {G, G, R, R, R, 4'b1001};
  localparam logic [18:0] P_MY  = {Y, Y, R, R, R, 4'b0101};
  localparam logic [18:0] P_RED = {R, R, R, R, R, 4'b0101};
  localparam logic [18:0] P_SG  = {R, R, G, R, R, 4'b0101};
  localparam logic [18:0] P_SY  = {R, R, Y, R, R, 4'b0101};
  localparam logic [18:0] P_PED = {R, R, G, R, R, 4'b1001};
  localparam logic [18:0] P_L1G = {R, G, R, G, R, 4'b0101};
  localparam logic [18:0] P_L1Y = {G, R, R, Y, R, 4'b0101};
  localparam logic [18:0] P_L1C = {G, R, R, R, R, 4'b0101};
  localparam logic [18:0] P_L2G = {G, R, R, R, G, 4'b0101};
  localparam logic [18:0] P_L2Y = {R, G, R, R, Y, 4'b0101};
  localparam logic [18:0] P_L2C = {R, G, R, R, R, 4'b0101};
  localparam logic [18:0] P_BG  = {R, R, R, G, G, 4'b0101};
  localparam logic [18:0] P_BY  = {R, R, R, Y, Y, 4'b0101};

  task automatic expect_run(input logic [18:0] exp, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      nchk++;
      if (obs !== exp) begin
        nerr++;
        $display("FAIL %s: got %b expected %b", tag, obs, exp);
      end
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_left1 = 1'b0; req_left2 = 1'b0; req_walk = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic main_half(input string tag);
    expect_run(P_MG, 9, tag);
    expect_run(P_MY, 4, tag);
    expect_run(P_RED, 1, tag);
  endtask

  task automatic side_half(input string tag);
    expect_run(P_SG, 6, tag);
    expect_run(P_SY, 4, tag);
    expect_run(P_RED, 1, tag);
  endtask

  task automatic test_default();
    do_reset();
    expect_run(P_MG, 1, "R1 reset state");
    expect_run(P_MG, 8, "R2 main green");
    expect_run(P_MY, 4, "R2 main yellow");
    expect_run(P_RED, 1, "R12 first all-red");
    expect_run(P_SG, 6, "R2 side green");
    expect_run(P_SY, 4, "R2 side yellow R11");
    expect_run(P_RED, 1, "R12 second all-red");
    main_half("R2 second cycle");
    expect_run(P_SG, 3, "R4 side green");
    rst = 1'b1;
    #1;
    nchk++;
    if (obs !== P_MG) begin
      nerr++;
      $display("FAIL R1 async reset: got %b expected %b", obs, P_MG);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_walk();
    do_reset();
    req_walk = 1'b1;
    expect_run(P_MG, 1, "R9 walk pulse");
    req_walk = 1'b0;
    expect_run(P_MG, 8, "R9");
    expect_run(P_MY, 4, "R9");
    expect_run(P_RED, 1, "R9");
    expect_run(P_PED, 9, "R5 walk green");
    expect_run(P_SY, 4, "R5 side yellow");
    expect_run(P_RED, 1, "R5 all-red");
    main_half("R5 back to main");
    expect_run(P_SG, 6, "R9 walk consumed");
  endtask

  task automatic test_left(input bit use1, input bit use2, input string tag);
    do_reset();
    req_left1 = use1; req_left2 = use2;
    expect_run(P_MG, 1, tag);
    req_left1 = 1'b0; req_left2 = 1'b0;
    expect_run(P_MG, 8, tag);
    expect_run(P_MY, 4, tag);
    expect_run(P_RED, 1, tag);
    side_half(tag);
    if (use1 && use2) begin
      expect_run(P_BG, 9, "R8 dual green");
      expect_run(P_BY, 4, "R8 dual yellow");
      expect_run(P_RED, 1, "R8 R12 dual all-red");
    end else if (use1) begin
      expect_run(P_L1G, 9, "R6 L1 green");
      expect_run(P_L1Y, 4, "R6 L1 yellow");
      expect_run(P_L1C, 1, "R6 L1 clear");
    end else begin
      expect_run(P_L2G, 9, "R7 L2 green");
      expect_run(P_L2Y, 4, "R7 L2 yellow");
      expect_run(P_L2C, 1, "R7 L2 clear");
    end
    main_half("R9 after turn");
    side_half("R9 after turn");
    expect_run(P_MG, 1, "R9 turn consumed");
  endtask

  task automatic test_rerequest();
    do_reset();
    req_left1 = 1'b1;
    expect_run(P_MG, 1, "R10");
    req_left1 = 1'b0;
    expect_run(P_MG, 8, "R10");
    expect_run(P_MY, 4, "R10");
    expect_run(P_RED, 1, "R10");
    side_half("R10");
    req_left1 = 1'b1;
    expect_run(P_L1G, 1, "R10 pulse in L1 phase");
    req_left1 = 1'b0;
    expect_run(P_L1G, 8, "R10");
    expect_run(P_L1Y, 4, "R10");
    expect_run(P_L1C, 1, "R10");
    main_half("R10 next cycle");
    side_half("R10 next cycle");
    expect_run(P_L1G, 1, "R10 L1 served again");
    do_reset();
    req_walk = 1'b1;
    expect_run(P_MG, 1, "R10 walk");
    req_walk = 1'b0;
    expect_run(P_MG, 8, "R10");
    expect_run(P_MY, 4, "R10");
    expect_run(P_RED, 1, "R10");
    req_walk = 1'b1;
    expect_run(P_PED, 1, "R10 pulse in walk phase");
    req_walk = 1'b0;
    expect_run(P_PED, 8, "R10");
    expect_run(P_SY, 4, "R10");
    expect_run(P_RED, 1, "R10");
    main_half("R10");
    expect_run(P_PED, 1, "R10 walk served again");
  endtask

  initial begin
    test_default();
    test_walk();
    test_left(1'b1, 1'b0, "R6 L1 path");
    test_left(1'b0, 1'b1, "R7 L2 path");
    test_left(1'b1, 1'b1, "R8 dual path");
    test_rerequest();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule